// File: doc/BRIEF.md
# I/O Page Translation Lookup

This block turns a device DMA address into a system memory address. It reads a table that holds one 64-bit translation entry for each I/O page. A request carries an address and a read/write flag. The block drops the in-page offset, reads the entry for that page from an internal RAM, and returns four things: the page-aligned I/O address, the page-aligned translated address, an offset mask and a two-bit access code. It also flags whether the requested direction is allowed. Two configuration inputs set the page size (as a shift) and the number of valid table entries.

The controller is a three-state machine:
- `ST_CLEAR` is entered on reset. It writes zero to one table entry per cycle and leaves after the last entry.
- `ST_IDLE` raises `req_ready`. A request accepted here moves the machine to `ST_READ` and starts the RAM read.
- `ST_READ` presents the result with `rsp_valid` for one cycle and then returns to `ST_IDLE`.

A companion block fills the table through a single-entry update port. Updates are accepted in `ST_IDLE` and `ST_READ`. They are dropped in `ST_CLEAR`.

Top module: `tce_xlate`

## Requirements
- R1: After reset the block stays in `ST_CLEAR` with `req_ready` low for exactly DEPTH clock cycles, writing zero to every entry. It then raises `req_ready`. Any page looked up before an update reads access code 0.
- R2: The entry index is `req_addr` shifted right by the effective page shift.
- R3: A request whose index is not below min(`cfg_entries`, DEPTH) is out of window. Its result has access code 0, I/O address 0, translated address 0, an all-ones offset mask and the violation flag set.
- R4: `rsp_perm` equals bits [1:0] of the entry. Code 0 is no access, 1 is read-only, 2 is write-only and 3 is read-write.
- R5: `rsp_paddr` is the entry value with bits below the effective page shift cleared.
- R6: `rsp_iova` is `req_addr` with bits below the effective page shift cleared. `rsp_mask` is (1 << shift) - 1.
- R7: `rsp_valid` is high for one cycle, in the cycle after the clock edge that accepted the request. `req_ready` is low in that cycle.
- R8: `rsp_violation` is 1 for a write (`req_write`=1) when access-code bit 1 is clear, and for a read when access-code bit 0 is clear. Otherwise it is 0.
- R9: An update (`upd_en`) writes `upd_data` to entry `upd_index` on the clock edge, and later lookups see it. An update issued during `ST_CLEAR` has no effect.
- R10: A `cfg_page_shift` below 12 acts as 12, and one above 24 acts as 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts table clearing |
| cfg_page_shift | input | 5 | Page size as log2, effective range 12..24 |
| cfg_entries | input | CNT_W | Number of valid table entries |
| upd_en | input | 1 | Table entry write strobe from the update block |
| upd_index | input | IDX_W | Entry index to write |
| upd_data | input | 64 | Entry value to write |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | Device I/O address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Result strobe |
| rsp_iova | output | 64 | Page-aligned I/O address |
| rsp_paddr | output | 64 | Page-aligned translated address |
| rsp_mask | output | 64 | In-page offset mask |
| rsp_perm | output | 2 | Access code |
| rsp_violation | output | 1 | Requested direction not permitted |

## Verification
Each result is due in the cycle that follows the accepting clock edge, because the RAM read takes one registered stage. The bench drives a request on a falling edge and reads every result field on the next falling edge, one half-cycle after the accepting edge. It checks one cycle later that `rsp_valid` has dropped. `req_ready` should rise exactly DEPTH edges after reset release, so the bench counts edges and checks the cycle before and the cycle of the rise. Updates are applied one full edge before the lookup that reads them.

// File: rtl/tce_pkg.sv
package tce_pkg;
    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_READ  = 2'd2
    } xl_state_t;

    localparam logic [1:0] ACC_NONE  = 2'd0;
    localparam logic [1:0] ACC_READ  = 2'd1;
    localparam logic [1:0] ACC_WRITE = 2'd2;
    localparam logic [1:0] ACC_BOTH  = 2'd3;

    localparam int unsigned SHIFT_MIN = 12;
    localparam int unsigned SHIFT_MAX = 24;
endpackage

// File: rtl/tce_entry_ram.sv
module tce_entry_ram #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned DATA_W = 64,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/tce_access_check.sv
module tce_access_check
    import tce_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chk_valid,
    input  logic       in_window,
    input  logic [1:0] entry_code,
    input  logic       is_write,
    output logic [1:0] perm,
    output logic       violation
);
    always_comb begin
        perm = in_window ? entry_code : ACC_NONE;
        unique case (perm)
            ACC_NONE:  violation = 1'b1;
            ACC_READ:  violation = is_write;
            ACC_WRITE: violation = !is_write;
            default:   violation = 1'b0;
        endcase
    end

    AST_WRITE_NEEDS_WBIT: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && is_write && !perm[1] |-> violation); // R8
    AST_READ_NEEDS_RBIT: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && !is_write && !perm[0] |-> violation); // R8
    AST_OOW_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && !in_window |-> perm == ACC_NONE); // R3
endmodule

// File: rtl/tce_xlate.sv
module tce_xlate
    import tce_pkg::*;
#(
    parameter int unsigned DEPTH   = 256,
    parameter int unsigned ADDR_W  = 64,
    localparam int unsigned IDX_W  = $clog2(DEPTH),
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        cfg_page_shift,
    input  logic [CNT_W-1:0]  cfg_entries,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_index,
    input  logic [ADDR_W-1:0] upd_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_iova,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [ADDR_W-1:0] rsp_mask,
    output logic [1:0]        rsp_perm,
    output logic              rsp_violation
);
    xl_state_t         state, state_nx;
    logic [IDX_W-1:0]  clr_idx;
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_write;
    logic [4:0]        lat_shift;
    logic              lat_inwin;

    logic [4:0]        shift_eff;
    logic [CNT_W-1:0]  cnt_eff;
    logic [ADDR_W-1:0] idx_full;
    logic              in_win;
    logic              accept;

    logic              ram_we;
    logic [IDX_W-1:0]  ram_waddr;
    logic [ADDR_W-1:0] ram_wdata;
    logic [ADDR_W-1:0] ram_rdata;
    logic [ADDR_W-1:0] lo_mask;

    // request decode: shift clamp, window bound, entry index
    always_comb begin
        if (cfg_page_shift < 5'(SHIFT_MIN))      shift_eff = 5'(SHIFT_MIN);
        else if (cfg_page_shift > 5'(SHIFT_MAX)) shift_eff = 5'(SHIFT_MAX);
        else                                     shift_eff = cfg_page_shift;
        cnt_eff  = (cfg_entries > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : cfg_entries;
        idx_full = req_addr >> shift_eff;
        in_win   = idx_full < ADDR_W'(cnt_eff);
        accept   = req_valid && req_ready;
    end

    // table write arbitration: clearing owns the port
    always_comb begin
        if (state == ST_CLEAR) begin
            ram_we    = 1'b1;
            ram_waddr = clr_idx;
            ram_wdata = '0;
        end else begin
            ram_we    = upd_en;
            ram_waddr = upd_index;
            ram_wdata = upd_data;
        end
    end

    tce_entry_ram #(.DEPTH(DEPTH), .DATA_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .re    (accept),
        .raddr (idx_full[IDX_W-1:0]),
        .rdata (ram_rdata)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAR: if (clr_idx == IDX_W'(DEPTH - 1)) state_nx = ST_IDLE;
            ST_IDLE:  if (req_valid) state_nx = ST_READ;
            ST_READ:  state_nx = ST_IDLE;
            default:  state_nx = ST_CLEAR;
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_CLEAR;
            clr_idx   <= '0;
            lat_addr  <= '0;
            lat_write <= 1'b0;
            lat_shift <= 5'(SHIFT_MIN);
            lat_inwin <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_CLEAR) begin
                clr_idx <= clr_idx + 1'b1;
            end
            if (accept) begin
                lat_addr  <= req_addr;
                lat_write <= req_write;
                lat_shift <= shift_eff;
                lat_inwin <= in_win;
            end
        end
    end

    tce_access_check u_chk (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_valid  (rsp_valid),
        .in_window  (lat_inwin),
        .entry_code (ram_rdata[1:0]),
        .is_write   (lat_write),
        .perm       (rsp_perm),
        .violation  (rsp_violation)
    );

    // outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_READ);
        lo_mask   = (ADDR_W'(1) << lat_shift) - ADDR_W'(1);
        if (lat_inwin) begin
            rsp_iova  = lat_addr & ~lo_mask;
            rsp_paddr = ram_rdata & ~lo_mask;
            rsp_mask  = lo_mask;
        end else begin
            rsp_iova  = '0;
            rsp_paddr = '0;
            rsp_mask  = '1;
        end
    end

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid); // R7
    AST_RSP_ONLY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready)); // R7
    AST_NO_READY_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R7
    AST_PADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_paddr & rsp_mask) == '0); // R5
    AST_IOVA_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_iova & rsp_mask) == '0); // R6
    AST_FULL_MASK_IS_OOW: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_mask == '1 |-> rsp_perm == ACC_NONE && rsp_paddr == '0); // R3
endmodule

// File: tb/tce_xlate_bench.sv
`timescale 1ns/1ps
module tce_xlate_bench;
    localparam int DEPTH = 256;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [4:0]       cfg_page_shift = 5'd12;
    logic [CNT_W-1:0] cfg_entries = CNT_W'(DEPTH);
    logic             upd_en = 1'b0;
    logic [IDX_W-1:0] upd_index = '0;
    logic [63:0]      upd_data = '0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [63:0]      req_addr = '0;
    logic             req_write = 1'b0;
    logic             rsp_valid;
    logic [63:0]      rsp_iova, rsp_paddr, rsp_mask;
    logic [1:0]       rsp_perm;
    logic             rsp_violation;

    int checks = 0;
    int errors = 0;

    logic        r_valid, r_ready, r_valid_after, r_viol;
    logic [63:0] r_iova, r_paddr, r_mask;
    logic [1:0]  r_perm;

    always #4 clk = ~clk;

    tce_xlate #(.DEPTH(DEPTH)) u_tce_xlate (
        .clk(clk), .rst_n(rst_n),
        .cfg_page_shift(cfg_page_shift), .cfg_entries(cfg_entries),
        .upd_en(upd_en), .upd_index(upd_index), .upd_data(upd_data),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_iova(rsp_iova), .rsp_paddr(rsp_paddr),
        .rsp_mask(rsp_mask), .rsp_perm(rsp_perm), .rsp_violation(rsp_violation)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_update(input int idx, input logic [63:0] val);
        @(negedge clk);
        upd_en = 1'b1; upd_index = IDX_W'(idx); upd_data = val;
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    task automatic do_lookup(input logic [63:0] a, input logic w);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        r_valid = rsp_valid; r_ready = req_ready;
        r_iova = rsp_iova; r_paddr = rsp_paddr; r_mask = rsp_mask;
        r_perm = rsp_perm; r_viol = rsp_violation;
        @(negedge clk);
        r_valid_after = rsp_valid;
    endtask

    task automatic t_reset_clear();
        logic early_ready = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 rsp_valid low in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        for (int k = 1; k < DEPTH; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (req_ready) early_ready = 1'b1;
            if (k == 10) begin
                upd_en = 1'b1; upd_index = IDX_W'(2); upd_data = 64'hFFFF_0003;
            end else begin
                upd_en = 1'b0;
            end
        end
        check("R1 ready low while clearing", 64'(early_ready), 64'd0);
        @(posedge clk);
        @(negedge clk);
        check("R1 ready high after DEPTH cycles", 64'(req_ready), 64'd1);
    endtask

    task automatic t_cleared_pages();
        cfg_page_shift = 5'd12; cfg_entries = CNT_W'(DEPTH);
        do_lookup(64'h0000_0000_0000_0123, 1'b0);
        check("R1 page 0 code after clear", 64'(r_perm), 64'd0);
        check("R8 read of cleared page violates", 64'(r_viol), 64'd1);
        check("R6 mask for shift 12", r_mask, 64'hFFF);
        do_lookup(64'h0000_0000_0000_2040, 1'b1);
        check("R9 update during clear dropped", 64'(r_perm), 64'd0);
        check("R5 cleared page paddr", r_paddr, 64'd0);
    endtask

    task automatic t_access_codes();
        cfg_page_shift = 5'd12;
        do_update(3, 64'h0000_0000_ABCD_E001);
        do_update(4, 64'h0000_0001_0000_0002);
        do_update(7, 64'h0000_0000_7777_7FFB);
        do_lookup(64'h0000_0000_0000_3123, 1'b0);
        check("R7 rsp_valid in cycle after accept", 64'(r_valid), 64'd1);
        check("R7 ready low during response", 64'(r_ready), 64'd0);
        check("R7 rsp_valid single cycle", 64'(r_valid_after), 64'd0);
        check("R4 read-only code", 64'(r_perm), 64'd1);
        check("R6 iova page base", r_iova, 64'h3000);
        check("R5 paddr page base", r_paddr, 64'hABCD_E000);
        check("R8 read of read-only ok", 64'(r_viol), 64'd0);
        do_lookup(64'h0000_0000_0000_3FFF, 1'b1);
        check("R8 write to read-only violates", 64'(r_viol), 64'd1);
        do_lookup(64'h0000_0000_0000_4010, 1'b0);
        check("R4 write-only code", 64'(r_perm), 64'd2);
        check("R8 read of write-only violates", 64'(r_viol), 64'd1);
        check("R5 high paddr bits kept", r_paddr, 64'h0000_0001_0000_0000);
        do_lookup(64'h0000_0000_0000_4010, 1'b1);
        check("R8 write to write-only ok", 64'(r_viol), 64'd0);
        do_lookup(64'h0000_0000_0000_7ABC, 1'b1);
        check("R4 read-write code", 64'(r_perm), 64'd3);
        check("R8 write to read-write ok", 64'(r_viol), 64'd0);
        check("R5 paddr with low bits set in entry", r_paddr, 64'h7777_7000);
    endtask

    task automatic t_window();
        cfg_page_shift = 5'd12; cfg_entries = CNT_W'(16);
        do_update(15, 64'h0000_0000_0F00_0003);
        do_lookup(64'h0000_0000_0000_FABC, 1'b0);
        check("R3 last in-window page code", 64'(r_perm), 64'd3);
        check("R2 last in-window paddr", r_paddr, 64'h0F00_0000);
        do_lookup(64'h0000_0000_0001_0ABC, 1'b0);
        check("R3 oow code", 64'(r_perm), 64'd0);
        check("R3 oow mask", r_mask, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R3 oow iova", r_iova, 64'd0);
        check("R3 oow paddr", r_paddr, 64'd0);
        check("R3 oow violation", 64'(r_viol), 64'd1);
        cfg_entries = CNT_W'(300);
        do_lookup(64'h0000_0000_0010_0000, 1'b0);
        check("R3 count above DEPTH limited", r_mask, 64'hFFFF_FFFF_FFFF_FFFF);
        do_lookup(64'h8000_0000_0000_3000, 1'b0);
        check("R2 high address bits out of window", 64'(r_perm), 64'd0);
        cfg_entries = CNT_W'(DEPTH);
    endtask

    task automatic t_shifts();
        cfg_page_shift = 5'd16;
        do_update(2, 64'h1234_5678_9ABC_FFF3);
        do_lookup(64'h0000_0000_0002_ABCD, 1'b1);
        check("R2 index at shift 16", 64'(r_perm), 64'd3);
        check("R6 iova at shift 16", r_iova, 64'h0002_0000);
        check("R6 mask at shift 16", r_mask, 64'hFFFF);
        check("R5 paddr at shift 16", r_paddr, 64'h1234_5678_9ABC_0000);
        cfg_page_shift = 5'd5;
        do_lookup(64'h0000_0000_0000_3123, 1'b0);
        check("R10 low shift clamps to 12 index", 64'(r_perm), 64'd1);
        check("R10 low shift clamps to 12 mask", r_mask, 64'hFFF);
        cfg_page_shift = 5'd30;
        do_update(1, 64'h0000_00AB_CDEF_1235);
        do_lookup(64'h0000_0000_01FF_FFFF, 1'b0);
        check("R10 high shift clamps to 24 mask", r_mask, 64'hFF_FFFF);
        check("R10 high shift paddr", r_paddr, 64'h0000_00AB_CD00_0000);
        check("R4 code from entry bits", 64'(r_perm), 64'd1);
        cfg_page_shift = 5'd12;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_clear();
        t_cleared_pages();
        t_access_codes();
        t_window();
        t_shifts();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule